// File: doc/BRIEF.md
# Three-Port Banked Shared RAM

This block is a clocked memory of 16-bit words, held in two banks of 4096 words each, that three ports can use at the same time. The first port can reach either bank. It picks one through a pair of active-low bank selects, and it must never assert both selects together. The second port is tied to bank 0 and the third port to bank 1, and each of them is gated by an active-low chip enable.

Every port has a 12-bit word address, a direction strobe (high reads, low writes), an active-low output enable, a write-data input, and a registered read-data output with a valid flag. These outputs take the place of a shared bidirectional bus. The block does not arbitrate between ports. Software above it must keep ports from colliding on one word. The block also flags the forbidden select pattern on the first port, and it reports a standby condition when the first and third ports are both idle.

Top module: `tri_port_bank_ram`

## Requirements
- R1: With `p1_sel_n` = 2'b10 (bit 0 low), a port-1 access targets bank 0, and a port-1 write becomes visible to reads on port 2 at the same address.
- R2: With `p1_sel_n` = 2'b01 (bit 1 low), a port-1 access targets bank 1, and a port-1 write becomes visible to reads on port 3 and leaves bank 0 untouched.
- R3: While `p1_sel_n` = 2'b00, `sel_fault` is high in the same cycle, no word in either bank is written by port 1, and `p1_rvalid` is low in the following cycle; `sel_fault` is low for every other pattern.
- R4: With `p1_sel_n` = 2'b11, port 1 is deselected: it writes nothing and its `p1_rvalid` is low in the next cycle.
- R5: Port 2 reaches only bank 0 and port 3 only bank 1, and each accesses its bank only while its `_en_n` is low.
- R6: A write stores `wdata` at `addr` in the selected bank when the port is enabled and `rw` is low; the stored word is returned by a later read.
- R7: A read (port enabled, `rw` high, `oe_n` low) drives `rvalid` high and `rdata` to the stored word one clock later; in every other case `rvalid` and `rdata` are zero one clock later.
- R8: With `oe_n` high, a port gives no read output (`rvalid` low next cycle) whatever its other inputs are.
- R9: `standby` is high exactly when both bits of `p1_sel_n` and `p3_en_n` are high.
- R10: After reset every word of both banks reads as zero, and all `rvalid` and `rdata` outputs are zero.
- R11: The three ports act independently: accesses in the same cycle to different words all take effect as if each were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p1_addr | input | 12 | Port 1 word address |
| p1_sel_n | input | 2 | Port 1 bank selects, active low; bit 0 = bank 0, bit 1 = bank 1 |
| p1_rw | input | 1 | Port 1 direction, 1 = read, 0 = write |
| p1_oe_n | input | 1 | Port 1 output enable, active low |
| p1_wdata | input | 16 | Port 1 write data |
| p1_rdata | output | 16 | Port 1 read data, zero when not valid |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p2_addr | input | 12 | Port 2 word address (bank 0) |
| p2_en_n | input | 1 | Port 2 chip enable, active low |
| p2_rw | input | 1 | Port 2 direction, 1 = read |
| p2_oe_n | input | 1 | Port 2 output enable, active low |
| p2_wdata | input | 16 | Port 2 write data |
| p2_rdata | output | 16 | Port 2 read data |
| p2_rvalid | output | 1 | Port 2 read data valid |
| p3_addr | input | 12 | Port 3 word address (bank 1) |
| p3_en_n | input | 1 | Port 3 chip enable, active low |
| p3_rw | input | 1 | Port 3 direction, 1 = read |
| p3_oe_n | input | 1 | Port 3 output enable, active low |
| p3_wdata | input | 16 | Port 3 write data |
| p3_rdata | output | 16 | Port 3 read data |
| p3_rvalid | output | 1 | Port 3 read data valid |
| sel_fault | output | 1 | Both port-1 bank selects active |
| standby | output | 1 | Port 1 and port 3 both idle |

## Verification
A wrong bank decode or a write that should have been gated stays hidden in the array until some port reads that word. So the bench reads words back through the other ports, and a routing error shows up one cycle after that read. The bench keeps its own image of both banks. It writes through one port and reads through another, which exposes crossed banks, lost writes, and writes leaking out during a select fault. The fault and standby decodes are combinational and are checked in the same cycle as the stimulus. A stuck or early valid flag appears on the very next edge.

// File: rtl/tri_port_bank_ram.sv
module tri_port_bank_ram #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] p1_addr,
  input  logic [1:0]    p1_sel_n,
  input  logic          p1_rw,
  input  logic          p1_oe_n,
  input  logic [DW-1:0] p1_wdata,
  output logic [DW-1:0] p1_rdata,
  output logic          p1_rvalid,
  input  logic [AW-1:0] p2_addr,
  input  logic          p2_en_n,
  input  logic          p2_rw,
  input  logic          p2_oe_n,
  input  logic [DW-1:0] p2_wdata,
  output logic [DW-1:0] p2_rdata,
  output logic          p2_rvalid,
  input  logic [AW-1:0] p3_addr,
  input  logic          p3_en_n,
  input  logic          p3_rw,
  input  logic          p3_oe_n,
  input  logic [DW-1:0] p3_wdata,
  output logic [DW-1:0] p3_rdata,
  output logic          p3_rvalid,
  output logic          sel_fault,
  output logic          standby
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] bank0 [DEPTH];
  logic [DW-1:0] bank1 [DEPTH];

  logic p1_on0, p1_on1, p1_on;
  logic p1_wr0, p1_wr1, p2_wr, p3_wr;
  logic p1_rd, p2_rd, p3_rd;

  assign p1_on0 = (p1_sel_n == 2'b10);
  assign p1_on1 = (p1_sel_n == 2'b01);
  assign p1_on  = p1_on0 | p1_on1;

  assign sel_fault = (p1_sel_n == 2'b00);
  assign standby   = (p1_sel_n == 2'b11) & p3_en_n;

  assign p1_wr0 = p1_on0 & ~p1_rw;
  assign p1_wr1 = p1_on1 & ~p1_rw;
  assign p2_wr  = ~p2_en_n & ~p2_rw;
  assign p3_wr  = ~p3_en_n & ~p3_rw;

  assign p1_rd = p1_on & p1_rw & ~p1_oe_n;
  assign p2_rd = ~p2_en_n & p2_rw & ~p2_oe_n;
  assign p3_rd = ~p3_en_n & p3_rw & ~p3_oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank0[i] <= '0;
    end else begin
      if (p2_wr)  bank0[p2_addr] <= p2_wdata;
      if (p1_wr0) bank0[p1_addr] <= p1_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank1[i] <= '0;
    end else begin
      if (p3_wr)  bank1[p3_addr] <= p3_wdata;
      if (p1_wr1) bank1[p1_addr] <= p1_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_rvalid <= 1'b0;
      p2_rvalid <= 1'b0;
      p3_rvalid <= 1'b0;
      p1_rdata  <= '0;
      p2_rdata  <= '0;
      p3_rdata  <= '0;
    end else begin
      p1_rvalid <= p1_rd;
      p2_rvalid <= p2_rd;
      p3_rvalid <= p3_rd;
      p1_rdata  <= p1_rd ? (p1_on1 ? bank1[p1_addr] : bank0[p1_addr]) : '0;
      p2_rdata  <= p2_rd ? bank0[p2_addr] : '0;
      p3_rdata  <= p3_rd ? bank1[p3_addr] : '0;
    end
  end

  a_r3_fault_blocks_writes: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fault |-> !p1_wr0 && !p1_wr1);
  a_r3_fault_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fault |=> !p1_rvalid);
  a_r3_fault_not_standby: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fault |-> !standby);
  a_r8_oe_gates_p1: assert property (@(posedge clk) disable iff (!rst_n)
    p1_oe_n |=> !p1_rvalid);
  a_r8_oe_gates_p2: assert property (@(posedge clk) disable iff (!rst_n)
    p2_oe_n |=> !p2_rvalid);
  a_r5_p3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    p3_en_n |=> !p3_rvalid);
  a_r9_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !p1_rvalid && !p3_rvalid);
  a_r7_data_zero_unless_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !p1_rvalid |-> p1_rdata == '0);
  a_r7_p2_zero_unless_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !p2_rvalid |-> p2_rdata == '0);
endmodule

// File: tb/tri_port_bank_ram_tb_top.sv
module tri_port_bank_ram_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0] a  [3];
  logic [1:0]  en [3];
  logic        rw [3];
  logic        oe [3];
  logic [15:0] wd [3];
  logic        rv [3];
  logic [15:0] rd [3];
  logic        sel_fault, standby;

  logic [15:0] m0 [4096];
  logic [15:0] m1 [4096];
  logic        exp_v [3];
  logic [15:0] exp_d [3];
  string       tag;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  tri_port_bank_ram dut_i (
    .clk(clk), .rst_n(rst_n),
    .p1_addr(a[0]), .p1_sel_n(en[0]), .p1_rw(rw[0]), .p1_oe_n(oe[0]), .p1_wdata(wd[0]),
    .p1_rdata(rd[0]), .p1_rvalid(rv[0]),
    .p2_addr(a[1]), .p2_en_n(en[1][0]), .p2_rw(rw[1]), .p2_oe_n(oe[1]), .p2_wdata(wd[1]),
    .p2_rdata(rd[1]), .p2_rvalid(rv[1]),
    .p3_addr(a[2]), .p3_en_n(en[2][0]), .p3_rw(rw[2]), .p3_oe_n(oe[2]), .p3_wdata(wd[2]),
    .p3_rdata(rd[2]), .p3_rvalid(rv[2]),
    .sel_fault(sel_fault), .standby(standby)
  );

  function automatic int bank_of(int p, logic [1:0] e);
    if (p == 0) return (e == 2'b10) ? 0 : (e == 2'b01) ? 1 : -1;
    if (e[0]) return -1;
    return (p == 1) ? 0 : 1;
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic idle_all();
    for (int p = 0; p < 3; p++) begin
      a[p] = '0; en[p] = 2'b11; rw[p] = 1'b1; oe[p] = 1'b1; wd[p] = '0;
    end
  endtask

  task automatic set(int p, logic [11:0] ad, logic [1:0] e, logic r, logic o, logic [15:0] d);
    a[p] = ad; en[p] = e; rw[p] = r; oe[p] = o; wd[p] = d;
  endtask

  task automatic cycle();
    int b;
    #1;
    check(tag, {31'd0, sel_fault}, {31'd0, en[0] == 2'b00}, "R3 sel_fault");
    check(tag, {31'd0, standby}, {31'd0, en[0] == 2'b11 && en[2][0]}, "R9 standby");
    for (int p = 0; p < 3; p++) begin
      b = bank_of(p, en[p]);
      exp_v[p] = (b >= 0) && rw[p] && !oe[p];
      exp_d[p] = !exp_v[p] ? 16'h0 : (b == 1 ? m1[a[p]] : m0[a[p]]);
    end
    for (int p = 2; p >= 0; p--) begin
      b = bank_of(p, en[p]);
      if (b == 0 && !rw[p]) m0[a[p]] = wd[p];
      if (b == 1 && !rw[p]) m1[a[p]] = wd[p];
    end
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      check(tag, {31'd0, rv[p]}, {31'd0, exp_v[p]}, $sformatf("port%0d rvalid", p + 1));
      check(tag, {16'd0, rd[p]}, {16'd0, exp_d[p]}, $sformatf("port%0d rdata", p + 1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 4096; i++) begin m0[i] = '0; m1[i] = '0; end
    for (int p = 0; p < 3; p++) begin exp_v[p] = 0; exp_d[p] = '0; end
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R10";
    for (int p = 0; p < 3; p++) begin
      check(tag, {31'd0, rv[p]}, 32'd0, "reset rvalid");
      check(tag, {16'd0, rd[p]}, 32'd0, "reset rdata");
    end
    set(0, 12'hFFF, 2'b10, 1, 0, 0); set(1, 12'h000, 2'b10, 1, 0, 0); set(2, 12'h7A5, 2'b10, 1, 0, 0);
    cycle();

    tag = "R1";
    idle_all(); set(0, 12'h123, 2'b10, 0, 1, 16'hA1A1); cycle();
    idle_all(); set(1, 12'h123, 2'b10, 1, 0, 0); set(2, 12'h123, 2'b10, 1, 0, 0); cycle();

    tag = "R2";
    idle_all(); set(0, 12'h123, 2'b01, 0, 1, 16'hB2B2); cycle();
    idle_all(); set(2, 12'h123, 2'b10, 1, 0, 0); set(1, 12'h123, 2'b10, 1, 0, 0); cycle();
    idle_all(); set(0, 12'h123, 2'b01, 1, 0, 0); cycle();

    tag = "R3";
    idle_all(); set(0, 12'h123, 2'b00, 0, 1, 16'hC3C3); cycle();
    idle_all(); set(0, 12'h123, 2'b00, 1, 0, 0); cycle();
    idle_all(); set(1, 12'h123, 2'b10, 1, 0, 0); set(2, 12'h123, 2'b10, 1, 0, 0); cycle();

    tag = "R4";
    idle_all(); set(0, 12'h123, 2'b11, 0, 0, 16'hD4D4); cycle();
    idle_all(); set(0, 12'h123, 2'b11, 1, 0, 0); set(1, 12'h123, 2'b10, 1, 0, 0); set(2, 12'h123, 2'b10, 1, 0, 0); cycle();

    tag = "R5";
    idle_all(); set(1, 12'h040, 2'b11, 0, 1, 16'hE5E5); set(2, 12'h040, 2'b11, 0, 1, 16'hE6E6); cycle();
    idle_all(); set(0, 12'h040, 2'b10, 1, 0, 0); set(2, 12'h040, 2'b10, 1, 0, 0); cycle();
    idle_all(); set(2, 12'h041, 2'b10, 0, 1, 16'h5151); cycle();
    idle_all(); set(0, 12'h041, 2'b10, 1, 0, 0); set(1, 12'h041, 2'b10, 1, 0, 0); cycle();
    idle_all(); set(0, 12'h041, 2'b01, 1, 0, 0); cycle();

    tag = "R6";
    idle_all(); set(1, 12'hABC, 2'b10, 0, 0, 16'h6060); cycle();
    idle_all(); set(0, 12'hABC, 2'b10, 1, 0, 0); set(1, 12'hABC, 2'b10, 1, 0, 0); cycle();

    tag = "R8";
    idle_all(); set(0, 12'hABC, 2'b10, 1, 1, 0); set(1, 12'hABC, 2'b10, 1, 1, 0); set(2, 12'h123, 2'b10, 1, 1, 0); cycle();

    tag = "R7";
    idle_all(); set(1, 12'hABC, 2'b10, 1, 0, 0); cycle();
    idle_all(); cycle();

    tag = "R9";
    idle_all(); set(2, 12'h0, 2'b10, 1, 1, 0); cycle();
    idle_all(); set(0, 12'h0, 2'b01, 1, 1, 0); cycle();
    idle_all(); cycle();

    tag = "R11";
    idle_all();
    set(0, 12'h300, 2'b10, 0, 1, 16'h1111); set(1, 12'h301, 2'b10, 0, 1, 16'h2222); set(2, 12'h300, 2'b10, 0, 1, 16'h3333);
    cycle();
    idle_all();
    set(0, 12'h301, 2'b10, 1, 0, 0); set(1, 12'h300, 2'b10, 1, 0, 0); set(2, 12'h300, 2'b10, 1, 0, 0);
    cycle();

    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      int b, c;
      for (int p = 0; p < 3; p++) begin
        a[p]  = ($urandom % 4 == 0) ? 12'($urandom) : 12'($urandom % 16);
        en[p] = 2'($urandom);
        if (p > 0 && ($urandom % 4 != 0)) en[p][0] = 1'b0;
        rw[p] = 1'($urandom);
        oe[p] = ($urandom % 5 == 0);
        wd[p] = 16'($urandom);
      end
      for (int p = 1; p < 3; p++) begin
        b = bank_of(p, en[p]);
        c = bank_of(0, en[0]);
        if (b >= 0 && b == c && a[p] == a[0] && (!rw[p] || !rw[0])) en[p] = 2'b11;
      end
      cycle();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule